// File: doc/BRIEF.md
# Programmable Bus Cycle Phase Timer

This block times one access cycle on a card interface. A cycle has three back-to-back phases: address setup, command strobe active and recovery. The length of each phase is a whole number of internal clock periods. It comes from one of three timing registers, each holding a multiplier field and a prescaler select. The host requests a cycle with a one-clock start request. The block then raises the phase indicators in turn and enables the command strobe only while the command phase lasts. On the final clock of recovery it pulses a done flag.

All three phase lengths are captured when a cycle launches. A register write made during a cycle therefore changes only later cycles. If a start request arrives while a cycle is running, it is held. The next cycle then begins on the clock right after recovery ends, with no idle clock between. The timing registers are written through a small select/data port and come out of reset with values that give a 2/7/4 clock cycle.

Top module: `pcyc_phase_timer`

## Requirements
- R1: Each cycle runs setup, then command, then recovery, with no gap between phases, and at most one phase indicator is high at any time. A start request seen while idle puts the block in setup on the next clock.
- R2: A phase lasts (multiplier << shift) + 1 clocks. A multiplier of zero gives a one-clock phase.
- R3: In each timing register, bits [MULT_W-1:0] hold the multiplier and the top two bits hold the prescaler select k. The prescaler is 2^(k*PRE_STEP), which with PRE_STEP=4 gives 1, 16, 256 or 4096.
- R4: After reset the setup, command and recovery registers hold 01h, 06h and 03h, so the phases last 2, 7 and 4 clocks.
- R5: The command strobe enable is high only during the command phase and low during setup, recovery and idle.
- R6: The done output is high for exactly one clock, the last clock of recovery. With no request pending the block is idle on the following clock.
- R7: All three phase lengths are captured from the register contents before the launch edge. A write on that edge, or during the cycle, only affects later cycles.
- R8: A start request during a running cycle, other than on its done clock, is held (several collapse into one). The next cycle's setup then begins on the clock after done.
- R9: A start request on the done clock starts the next setup on the following clock.
- R10: A write with select 0, 1 or 2 updates the setup, command or recovery register. Select 3 leaves all registers unchanged.
- R11: During and right after reset all phase outputs, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Request to run one access cycle |
| wr_en | input | 1 | Timing register write strobe |
| wr_sel | input | 2 | Register select: 0 setup, 1 command, 2 recovery, 3 none |
| wr_data | input | MULT_W+2 | Register write value: {prescaler select, multiplier} |
| setup_phase | output | 1 | High during address setup |
| cmd_strobe_en | output | 1 | High during the command phase |
| recovery_phase | output | 1 | High during recovery |
| busy | output | 1 | A cycle is running |
| cycle_done | output | 1 | One-clock pulse on the last recovery clock |

## Verification
The delicate coincidences are a start request on the very clock that recovery ends, and a register write on the clock that a cycle launches. The bench raises start_req exactly on the sampled done clock. It expects setup on the next clock with no idle gap, and it times the chained cycle's phases. It also writes the command register together with the launch request, and writes it again while setup is running. It then checks that the running cycle keeps the old command length and that the following cycle uses the new one.

// File: rtl/pcyc_pkg.sv
package pcyc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_CMD   = 2'd2,
      PH_REC   = 2'd3
   } phase_e;

   localparam int          NUM_TREGS  = 3;
   localparam int          SEL_W      = 2;
   localparam logic [1:0]  SEL_SETUP  = 2'd0;
   localparam logic [1:0]  SEL_CMD    = 2'd1;
   localparam logic [1:0]  SEL_REC    = 2'd2;

endpackage

// File: rtl/pcyc_timing_regs.sv
module pcyc_timing_regs
   import pcyc_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int RST_S   = 1,
   parameter int RST_C   = 6,
   parameter int RST_R   = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_W-1:0]               wr_sel,
   input  logic [REG_W-1:0]               wr_data,
   output logic [NUM_TREGS-1:0][REG_W-1:0] regs_o
);

   for (genvar g = 0; g < NUM_TREGS; g++) begin : g_reg
      localparam int RST_V = (g == 0) ? RST_S : ((g == 1) ? RST_C : RST_R);
      logic [REG_W-1:0] val_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= REG_W'(RST_V);
         end else if (wr_en && (wr_sel == SEL_W'(g))) begin
            val_q <= wr_data;
         end
      end

      assign regs_o[g] = val_q;
   end

endmodule

// File: rtl/pcyc_len_calc.sv
module pcyc_len_calc #(
   parameter int MULT_W   = 6,
   parameter int PRE_STEP = 4,
   parameter int CNT_W    = 19
) (
   input  logic [MULT_W+1:0] reg_i,
   output logic [CNT_W-1:0]  len_o
);

   logic [1:0]        pre_sel;
   logic [MULT_W-1:0] mult;
   logic [CNT_W-1:0]  scaled;

   assign pre_sel = reg_i[MULT_W+1:MULT_W];
   assign mult    = reg_i[MULT_W-1:0];

   if (PRE_STEP == 0) begin : g_noscale
      assign scaled = CNT_W'(mult);
   end else begin : g_scale
      always_comb begin
         scaled = '0;
         case (pre_sel)
            2'd0:    scaled = CNT_W'(mult);
            2'd1:    scaled = CNT_W'(mult) << PRE_STEP;
            2'd2:    scaled = CNT_W'(mult) << (2 * PRE_STEP);
            default: scaled = CNT_W'(mult) << (3 * PRE_STEP);
         endcase
      end
   end

   assign len_o = scaled + CNT_W'(1);

endmodule

// File: rtl/pcyc_sequencer.sv
module pcyc_sequencer
   import pcyc_pkg::*;
#(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic [CNT_W-1:0] len_s_i,
   input  logic [CNT_W-1:0] len_c_i,
   input  logic [CNT_W-1:0] len_r_i,
   output logic             setup_o,
   output logic             cmd_o,
   output logic             rec_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             held_o
);

   phase_e           st_q, st_d;
   logic [CNT_W-1:0] rem_q, rem_d;
   logic [CNT_W-1:0] snap_c_q, snap_r_q;
   logic             held_q, held_d;
   logic             last_clk;
   logic             launch;

   assign last_clk = (rem_q == '0);
   assign done_o   = (st_q == PH_REC) && last_clk;
   assign launch   = ((st_q == PH_IDLE) && start_req) ||
                     (done_o && (held_q || start_req));

   always_comb begin
      st_d   = st_q;
      rem_d  = rem_q;
      held_d = held_q;
      case (st_q)
         PH_SETUP: begin
            if (last_clk) begin
               st_d  = PH_CMD;
               rem_d = snap_c_q - CNT_W'(1);
            end else begin
               rem_d = rem_q - CNT_W'(1);
            end
         end
         PH_CMD: begin
            if (last_clk) begin
               st_d  = PH_REC;
               rem_d = snap_r_q - CNT_W'(1);
            end else begin
               rem_d = rem_q - CNT_W'(1);
            end
         end
         PH_REC: begin
            if (last_clk) begin
               st_d  = PH_IDLE;
               rem_d = '0;
            end else begin
               rem_d = rem_q - CNT_W'(1);
            end
         end
         default: begin
            st_d  = PH_IDLE;
            rem_d = '0;
         end
      endcase

      if (launch) begin
         st_d  = PH_SETUP;
         rem_d = len_s_i - CNT_W'(1);
      end

      if (done_o) begin
         held_d = 1'b0;
      end else if ((st_q != PH_IDLE) && start_req) begin
         held_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PH_IDLE;
         rem_q  <= '0;
         held_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         rem_q  <= rem_d;
         held_q <= held_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_c_q <= CNT_W'(1);
         snap_r_q <= CNT_W'(1);
      end else if (launch) begin
         snap_c_q <= len_c_i;
         snap_r_q <= len_r_i;
      end
   end

   assign setup_o = (st_q == PH_SETUP);
   assign cmd_o   = (st_q == PH_CMD);
   assign rec_o   = (st_q == PH_REC);
   assign busy_o  = (st_q != PH_IDLE);
   assign held_o  = held_q;

endmodule

// File: rtl/pcyc_phase_timer.sv
module pcyc_phase_timer
   import pcyc_pkg::*;
#(
   parameter int MULT_W    = 6,
   parameter int PRE_STEP  = 4,
   parameter int RST_SETUP = 1,
   parameter int RST_CMD   = 6,
   parameter int RST_REC   = 3,
   localparam int REG_W    = MULT_W + 2,
   localparam int CNT_W    = MULT_W + 3 * PRE_STEP + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic             setup_phase,
   output logic             cmd_strobe_en,
   output logic             recovery_phase,
   output logic             busy,
   output logic             cycle_done
);

   if (MULT_W < 1 || MULT_W > 16) begin : g_bad_mult
      $error("pcyc_phase_timer: MULT_W must lie in 1..16");
   end
   if (PRE_STEP < 0 || PRE_STEP > 8) begin : g_bad_step
      $error("pcyc_phase_timer: PRE_STEP must lie in 0..8");
   end
   if (RST_SETUP < 0 || RST_SETUP >= (1 << REG_W) ||
       RST_CMD   < 0 || RST_CMD   >= (1 << REG_W) ||
       RST_REC   < 0 || RST_REC   >= (1 << REG_W)) begin : g_bad_rst
      $error("pcyc_phase_timer: reset values exceed the register width");
   end

   logic [NUM_TREGS-1:0][REG_W-1:0] tregs;
   logic [NUM_TREGS-1:0][CNT_W-1:0] tlens;
   logic                            req_held;

   pcyc_timing_regs #(
      .REG_W (REG_W),
      .RST_S (RST_SETUP),
      .RST_C (RST_CMD),
      .RST_R (RST_REC)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .regs_o  (tregs)
   );

   for (genvar g = 0; g < NUM_TREGS; g++) begin : g_len
      pcyc_len_calc #(
         .MULT_W   (MULT_W),
         .PRE_STEP (PRE_STEP),
         .CNT_W    (CNT_W)
      ) i_len (
         .reg_i (tregs[g]),
         .len_o (tlens[g])
      );
   end

   pcyc_sequencer #(
      .CNT_W (CNT_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .len_s_i   (tlens[0]),
      .len_c_i   (tlens[1]),
      .len_r_i   (tlens[2]),
      .setup_o   (setup_phase),
      .cmd_o     (cmd_strobe_en),
      .rec_o     (recovery_phase),
      .busy_o    (busy),
      .done_o    (cycle_done),
      .held_o    (req_held)
   );

endmodule

// File: rtl/pcyc_phase_timer_chk.sv
module pcyc_phase_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic setup_phase,
   input logic cmd_strobe_en,
   input logic recovery_phase,
   input logic busy,
   input logic cycle_done,
   input logic req_held
);

   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({setup_phase, cmd_strobe_en, recovery_phase})); // R1

   AST_IDLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_req) |=> setup_phase); // R1

   AST_CMD_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_strobe_en) |-> $past(setup_phase)); // R5

   AST_REC_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recovery_phase) |-> $past(cmd_strobe_en)); // R1

   AST_DONE_IN_REC: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |-> recovery_phase); // R6

   AST_DONE_ENDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |=> !recovery_phase); // R6

   AST_HELD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && req_held) |=> setup_phase); // R8

   AST_NO_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_held); // R8

   AST_COINCIDENT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && start_req) |=> setup_phase); // R9

endmodule

bind pcyc_phase_timer pcyc_phase_timer_chk i_chk (.*);

// File: tb/test_pcyc_phase_timer.sv
`timescale 1ns/1ps
module test_pcyc_phase_timer;

   localparam int MULT_W   = 3;
   localparam int PRE_STEP = 1;
   localparam int REG_W    = MULT_W + 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_req = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_sel = 2'd0;
   logic [REG_W-1:0] wr_data = '0;
   logic             setup_phase, cmd_strobe_en, recovery_phase, busy, cycle_done;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   pcyc_phase_timer #(
      .MULT_W   (MULT_W),
      .PRE_STEP (PRE_STEP)
   ) i_pcyc_phase_timer (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_req      (start_req),
      .wr_en          (wr_en),
      .wr_sel         (wr_sel),
      .wr_data        (wr_data),
      .setup_phase    (setup_phase),
      .cmd_strobe_en  (cmd_strobe_en),
      .recovery_phase (recovery_phase),
      .busy           (busy),
      .cycle_done     (cycle_done)
   );

   function automatic int exp_len(input int v);
      int m = v % (1 << MULT_W);
      int k = v >> MULT_W;
      return (m << (k * PRE_STEP)) + 1;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input int sel, input int val);
      wr_en   = 1'b1;
      wr_sel  = 2'(sel);
      wr_data = REG_W'(val);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Samples from the current negedge (first setup clock) up to the done clock.
   task automatic monitor(input int es, input int ec, input int er, input string tag);
      int ns = 0, nc = 0, nr = 0, ov = 0, bad = 0, last = 0, g = 0;
      bit fin = 1'b0;
      while (!fin && g < 2000) begin
         int cur;
         cur = setup_phase ? 1 : (cmd_strobe_en ? 2 : (recovery_phase ? 3 : 0));
         if (int'(setup_phase) + int'(cmd_strobe_en) + int'(recovery_phase) > 1) ov++;
         if (cur == 0 || cur < last) bad++;
         last = cur;
         if (setup_phase) ns++;
         if (cmd_strobe_en) nc++;
         if (recovery_phase) nr++;
         if (cycle_done) begin
            if (!recovery_phase) bad++;
            fin = 1'b1;
         end
         g++;
         if (!fin) @(negedge clk);
      end
      check("R2", {tag, " setup clocks"}, ns, es);
      check("R5", {tag, " strobe clocks"}, nc, ec);
      check("R6", {tag, " recovery clocks up to done"}, nr, er);
      check("R1", {tag, " order/gap/overlap errors"}, ov + bad, 0);
   endtask

   task automatic run_cycle(input int es, input int ec, input int er, input string tag);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      monitor(es, ec, er, tag);
      @(negedge clk);
      check("R6", {tag, " idle after done"}, int'(busy) + int'(cycle_done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11", "outputs in reset", int'(setup_phase) + int'(cmd_strobe_en) +
            int'(recovery_phase) + int'(busy) + int'(cycle_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", "outputs after reset", int'(setup_phase) + int'(cmd_strobe_en) +
            int'(recovery_phase) + int'(busy) + int'(cycle_done), 0);

      // R4: defaults 01h/06h/03h give 2/7/4
      run_cycle(2, 7, 4, "R4 default");

      // R2/R3 sweeps of each register over every value
      for (int v = 0; v < (1 << REG_W); v++) begin
         write_reg(0, v);
         run_cycle(exp_len(v), 7, 4, $sformatf("R3 setup v=%0d", v));
      end
      write_reg(0, 1);
      for (int v = 0; v < (1 << REG_W); v++) begin
         write_reg(1, v);
         run_cycle(2, exp_len(v), 4, $sformatf("R3 cmd v=%0d", v));
      end
      write_reg(1, 6);
      for (int v = 0; v < (1 << REG_W); v++) begin
         write_reg(2, v);
         run_cycle(2, 7, exp_len(v), $sformatf("R3 rec v=%0d", v));
      end
      write_reg(2, 3);

      // R10: select 3 is ignored
      write_reg(3, 5'h1F);
      run_cycle(2, 7, 4, "R10 sel3 ignored");

      // R7: write during setup keeps this cycle's command length
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      fork
         monitor(2, 7, 4, "R7 midcycle write");
         write_reg(1, 2);
      join
      @(negedge clk);
      run_cycle(2, 3, 4, "R7 next cycle new cmd");

      // R7: write on the launch edge is not seen by that cycle
      start_req = 1'b1;
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = REG_W'(5'h0A);
      @(negedge clk);
      start_req = 1'b0; wr_en = 1'b0;
      monitor(2, 3, 4, "R7 launch-edge write");
      @(negedge clk);
      run_cycle(2, exp_len(5'h0A), 4, "R7 after launch-edge write");
      write_reg(1, 6);

      // R8: requests during a cycle are held and collapse into one
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (4) @(negedge clk);
      start_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start_req = 1'b0;
      for (int g = 0; g < 100 && !cycle_done; g++) @(negedge clk);
      @(negedge clk);
      check("R8", "setup right after done with held request", int'(setup_phase), 1);
      monitor(2, 7, 4, "R8 held cycle");
      @(negedge clk);
      check("R8", "single held launch then idle", int'(busy), 0);

      // R9: request exactly on the done clock
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      for (int g = 0; g < 100 && !cycle_done; g++) @(negedge clk);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      check("R9", "setup after request on done clock", int'(setup_phase), 1);
      monitor(2, 7, 4, "R9 chained cycle");
      @(negedge clk);
      check("R9", "idle after chained cycle", int'(busy), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule